// File: doc/BRIEF.md
# DAC Latch Update Scheduler

This block holds the two 8-bit data bytes that software writes for a 12-bit current-output DAC and decides when their contents move into the DAC input latch. The update can be tied to one of four timer overflow events, to a chosen edge of an external convert-start pin, or to the write of the high byte. With a hardware trigger, output changes follow a fixed sample clock and are not affected by software timing.

The block also turns the two bytes into a 12-bit code with a left- or right-justified layout. It stores a 2-bit full-scale range code and drives it to the analog section. Software writes three registers through a simple write port: control (address 0), low data (address 1) and high data (address 2). Address 3 is ignored.

Top module: `dac_update_sched`

## Requirements
- R1: After reset `dac_code` is 0x000 and `fs_range` is 2'b11. The control register comes up with update mode 3'b111 and left justification.
- R2: The control register holds the update mode in bits [6:4], the justification select in bit 2 and the range code in bits [1:0]. A control write shows its range code on `fs_range` after the next clock edge.
- R3: Mode 3'b000 loads the latch only on a `tmr0_ovf` pulse, and mode 3'b001 loads it only on a `tmr1_ovf` pulse.
- R4: Modes 3'b010 and 3'b011 use timer index 0 and 1 of the split-timer inputs. When that timer's `tmr_8bit` bit is 1 the latch loads on its `tmr_lo_ovf` pulse. When the bit is 0 it loads on its `tmr_hi_ovf` pulse.
- R5: Modes 3'b100, 3'b101 and 3'b110 load on a rising, a falling or any edge of `cnv_pin`. The pin passes two synchronizer flops and one compare flop, so `dac_code` changes at the third rising clock edge after the pin changes.
- R6: In modes 3'b000 to 3'b110, writes to the data registers do not change `dac_code` until the selected event occurs.
- R7: In mode 3'b111, a write to the high register loads the latch at that same clock edge, using the written high byte and the stored low byte. A low-byte write alone does not change `dac_code`.
- R8: With justification bit 0, the code is high[7:0] followed by low[7:4].
- R9: With justification bit 1, the code is high[3:0] followed by low[7:0].
- R10: When a trigger event and a data or control write fall in the same cycle (outside mode 3'b111), the latch takes the register contents and justification from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 low data, 2 high data |
| wr_data | input | 8 | Write data |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr_lo_ovf | input | 2 | Low-byte overflow pulses of the two split timers |
| tmr_hi_ovf | input | 2 | High-byte overflow pulses of the two split timers |
| tmr_8bit | input | 2 | 1 = split timer runs in 8-bit mode |
| cnv_pin | input | 1 | Asynchronous external convert-start pin |
| dac_code | output | 12 | DAC input latch contents |
| fs_range | output | 2 | Full-scale range code (11 = 2 mA, 10 = 1 mA, 01 = 0.5 mA, 00 = 0.25 mA) |

## Verification
The bench builds the block with its defaults: 8-bit registers, a 12-bit latch and a two-flop synchronizer. This is the only combination where both justified layouts exercise real byte slices and the pin latency is three edges. Random writes, timer pulses and pin toggles reach every update mode. This includes cycles where a trigger and a write coincide, and mode changes while the synchronizer pipeline still holds old pin values.

// File: rtl/dac_sched_pkg.sv
package dac_sched_pkg;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;

  localparam int CTL_MODE_LSB  = 4;
  localparam int CTL_RJ_BIT    = 2;
  localparam int CTL_RANGE_LSB = 0;

  typedef enum logic [2:0] {
    UPD_TMR0    = 3'd0,
    UPD_TMR1    = 3'd1,
    UPD_SPLIT0  = 3'd2,
    UPD_SPLIT1  = 3'd3,
    UPD_RISE    = 3'd4,
    UPD_FALL    = 3'd5,
    UPD_ANYEDGE = 3'd6,
    UPD_HIWRITE = 3'd7
  } upd_mode_e;
endpackage

// File: rtl/dac_sched_regs.sv
module dac_sched_regs
  import dac_sched_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output upd_mode_e         mode,
  output logic              rjust,
  output logic [1:0]        range,
  output logic [DATA_W-1:0] data_hi,
  output logic [DATA_W-1:0] data_lo,
  output logic              hi_wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= UPD_HIWRITE;
      rjust   <= 1'b0;
      range   <= 2'b11;
      data_hi <= '0;
      data_lo <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_CTRL: begin
          mode  <= upd_mode_e'(wr_data[CTL_MODE_LSB +: 3]);
          rjust <= wr_data[CTL_RJ_BIT];
          range <= wr_data[CTL_RANGE_LSB +: 2];
        end
        ADDR_LO: data_lo <= wr_data;
        ADDR_HI: data_hi <= wr_data;
        default: ;
      endcase
    end
  end

  assign hi_wr = wr_en && (wr_addr == ADDR_HI);
endmodule

// File: rtl/dac_sched_trig.sv
module dac_sched_trig
  import dac_sched_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_SPLIT     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  upd_mode_e          mode,
  input  logic               tmr0_ovf,
  input  logic               tmr1_ovf,
  input  logic [N_SPLIT-1:0] tmr_lo_ovf,
  input  logic [N_SPLIT-1:0] tmr_hi_ovf,
  input  logic [N_SPLIT-1:0] tmr_8bit,
  input  logic               cnv_pin,
  input  logic               hi_wr,
  output logic               load_evt
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0]  pin_pipe;
  logic               pin_now;
  logic               pin_prev;
  logic [N_SPLIT-1:0] split_ovf;

  always_ff @(posedge clk) begin
    if (rst) pin_pipe <= '0;
    else     pin_pipe <= {pin_pipe[PIPE_W-2:0], cnv_pin};
  end

  assign pin_now  = pin_pipe[SYNC_STAGES-1];
  assign pin_prev = pin_pipe[SYNC_STAGES];

  for (genvar i = 0; i < N_SPLIT; i++) begin : g_split
    assign split_ovf[i] = tmr_8bit[i] ? tmr_lo_ovf[i] : tmr_hi_ovf[i];
  end

  always_comb begin
    unique case (mode)
      UPD_TMR0:    load_evt = tmr0_ovf;
      UPD_TMR1:    load_evt = tmr1_ovf;
      UPD_SPLIT0:  load_evt = split_ovf[0];
      UPD_SPLIT1:  load_evt = split_ovf[N_SPLIT-1];
      UPD_RISE:    load_evt = pin_now & ~pin_prev;
      UPD_FALL:    load_evt = ~pin_now & pin_prev;
      UPD_ANYEDGE: load_evt = pin_now ^ pin_prev;
      default:     load_evt = hi_wr;
    endcase
  end
endmodule

// File: rtl/dac_sched_pack.sv
module dac_sched_pack #(
  parameter int DATA_W = 8,
  parameter int DAC_W  = 12
) (
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic              rjust,
  output logic [DAC_W-1:0]  code
);
  localparam int EXT_W = DAC_W - DATA_W;

  logic [DAC_W-1:0] left_code;
  logic [DAC_W-1:0] right_code;

  assign left_code  = {hi, lo[DATA_W-1 -: EXT_W]};
  assign right_code = {hi[EXT_W-1:0], lo};
  assign code       = rjust ? right_code : left_code;
endmodule

// File: rtl/dac_update_sched.sv
module dac_update_sched
  import dac_sched_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DAC_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int N_SPLIT     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               tmr0_ovf,
  input  logic               tmr1_ovf,
  input  logic [N_SPLIT-1:0] tmr_lo_ovf,
  input  logic [N_SPLIT-1:0] tmr_hi_ovf,
  input  logic [N_SPLIT-1:0] tmr_8bit,
  input  logic               cnv_pin,
  output logic [DAC_W-1:0]   dac_code,
  output logic [1:0]         fs_range
);
  upd_mode_e         mode_q;
  logic              rjust_q;
  logic [DATA_W-1:0] data_hi;
  logic [DATA_W-1:0] data_lo;
  logic              hi_wr;
  logic              load_evt;
  logic [DATA_W-1:0] hi_src;
  logic [DAC_W-1:0]  packed_code;

  dac_sched_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode_q), .rjust(rjust_q), .range(fs_range),
    .data_hi(data_hi), .data_lo(data_lo), .hi_wr(hi_wr)
  );

  dac_sched_trig #(.SYNC_STAGES(SYNC_STAGES), .N_SPLIT(N_SPLIT)) u_trig (
    .clk(clk), .rst(rst), .mode(mode_q),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .tmr_lo_ovf(tmr_lo_ovf), .tmr_hi_ovf(tmr_hi_ovf), .tmr_8bit(tmr_8bit),
    .cnv_pin(cnv_pin), .hi_wr(hi_wr), .load_evt(load_evt)
  );

  // In write-triggered mode the fresh high byte goes straight to the latch.
  assign hi_src = (mode_q == UPD_HIWRITE) ? wr_data : data_hi;

  dac_sched_pack #(.DATA_W(DATA_W), .DAC_W(DAC_W)) u_pack (
    .hi(hi_src), .lo(data_lo), .rjust(rjust_q), .code(packed_code)
  );

  always_ff @(posedge clk) begin
    if (rst)           dac_code <= '0;
    else if (load_evt) dac_code <= packed_code;
  end
endmodule

// File: rtl/dac_sched_chk.sv
module dac_sched_chk #(
  parameter int DATA_W  = 8,
  parameter int DAC_W   = 12,
  parameter int N_SPLIT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               tmr0_ovf,
  input logic [N_SPLIT-1:0] tmr_lo_ovf,
  input logic [N_SPLIT-1:0] tmr_hi_ovf,
  input logic [N_SPLIT-1:0] tmr_8bit,
  input logic [2:0]         mode,
  input logic               rjust,
  input logic               load_evt,
  input logic [DAC_W-1:0]   dac_code,
  input logic [1:0]         fs_range
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == '0 && fs_range == 2'b11));

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (fs_range == $past(wr_data[1:0])));

  assert_tmr0_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0) |-> (load_evt == tmr0_ovf));

  assert_split_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2) |-> (load_evt == (tmr_8bit[0] ? tmr_lo_ovf[0] : tmr_hi_ovf[0])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(load_evt) |-> $stable(dac_code));

  assert_hiwrite_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7 && wr_en && wr_addr == 2'd2 && !rjust)
      |=> (dac_code[DAC_W-1 -: DATA_W] == $past(wr_data)));
endmodule

bind dac_update_sched dac_sched_chk #(.DATA_W(DATA_W), .DAC_W(DAC_W), .N_SPLIT(N_SPLIT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tmr0_ovf(tmr0_ovf), .tmr_lo_ovf(tmr_lo_ovf), .tmr_hi_ovf(tmr_hi_ovf),
  .tmr_8bit(tmr_8bit), .mode(mode_q), .rjust(rjust_q), .load_evt(load_evt),
  .dac_code(dac_code), .fs_range(fs_range)
);

// File: tb/test_dac_update_sched.sv
module test_dac_update_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
  logic [1:0]  tmr_lo_ovf = '0, tmr_hi_ovf = '0, tmr_8bit = '0;
  logic        cnv_pin = 1'b0;
  logic [11:0] dac_code;
  logic [1:0]  fs_range;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Reference state built from the requirements
  logic [2:0]  m_mode;
  logic        m_rj;
  logic [1:0]  m_range;
  logic [7:0]  m_hi, m_lo;
  logic [11:0] m_latch;
  logic [2:0]  m_sync;

  always #5 clk = ~clk;

  dac_update_sched i_dac_update_sched (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr_lo_ovf(tmr_lo_ovf),
    .tmr_hi_ovf(tmr_hi_ovf), .tmr_8bit(tmr_8bit), .cnv_pin(cnv_pin),
    .dac_code(dac_code), .fs_range(fs_range)
  );

  function automatic logic [11:0] pack(input logic [7:0] h, input logic [7:0] l, input logic rj);
    return rj ? {h[3:0], l} : {h, l[7:4]};   // R9 : R8
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    if (m < 3'd2) return "R3";
    if (m < 3'd4) return "R4";
    if (m < 3'd7) return "R5";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 3'd7; m_rj = 1'b0; m_range = 2'b11;
    m_hi = '0; m_lo = '0; m_latch = '0; m_sync = '0;
  endtask

  task automatic model_eval();
    logic trig;
    logic cur, prev;
    cur = m_sync[1]; prev = m_sync[2];
    case (m_mode)
      3'd0: trig = tmr0_ovf;
      3'd1: trig = tmr1_ovf;
      3'd2: trig = tmr_8bit[0] ? tmr_lo_ovf[0] : tmr_hi_ovf[0];
      3'd3: trig = tmr_8bit[1] ? tmr_lo_ovf[1] : tmr_hi_ovf[1];
      3'd4: trig = cur & ~prev;
      3'd5: trig = ~cur & prev;
      3'd6: trig = cur ^ prev;
      default: trig = wr_en && wr_addr == 2'd2;
    endcase
    // R10: the latch sees pre-write registers, except the high byte in mode 7
    if (trig) m_latch = pack((m_mode == 3'd7) ? wr_data : m_hi, m_lo, m_rj);
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin m_mode = wr_data[6:4]; m_rj = wr_data[2]; m_range = wr_data[1:0]; end
        2'd1: m_lo = wr_data;
        2'd2: m_hi = wr_data;
        default: ;
      endcase
    end
    m_sync = {m_sync[1:0], cnv_pin};
  endtask

  task automatic step(input string tag);
    model_eval();
    @(posedge clk); #1;
    chk(tag, dac_code, m_latch);
    chk("R2", {10'd0, fs_range}, {10'd0, m_range});
  endtask

  task automatic clear_in();
    wr_en = 0; tmr0_ovf = 0; tmr1_ovf = 0; tmr_lo_ovf = '0; tmr_hi_ovf = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    clear_in();
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1", dac_code, 12'h000);
    chk("R1", {10'd0, fs_range}, 12'h003);

    // Mode 7, left justified
    wr(2'd1, 8'hA5, "R7");
    chk("R7", dac_code, 12'h000);
    wr(2'd2, 8'h3C, "R8");
    chk("R8", dac_code, 12'h3CA);

    // Mode 7, right justified, range 01
    wr(2'd0, 8'h75, "R2");
    chk("R2", {10'd0, fs_range}, 12'h001);
    wr(2'd2, 8'h1B, "R9");
    chk("R9", dac_code, 12'hBA5);

    // Mode 0 holds writes until timer 0
    wr(2'd0, 8'h03, "R6");
    wr(2'd2, 8'h11, "R6");
    wr(2'd1, 8'h22, "R6");
    chk("R6", dac_code, 12'hBA5);
    tmr1_ovf = 1; step("R3"); clear_in();
    chk("R3", dac_code, 12'hBA5);
    tmr0_ovf = 1; step("R3"); clear_in();
    chk("R3", dac_code, 12'h112);

    // R10: trigger and write together take the old contents
    wr(2'd0, 8'h13, "R10");
    wr(2'd1, 8'h40, "R10");
    tmr1_ovf = 1; wr(2'd2, 8'h99, "R10");
    chk("R10", dac_code, 12'h114);
    tmr1_ovf = 1; step("R10"); clear_in();
    chk("R10", dac_code, 12'h994);

    // R4: split timer 0 in 8-bit mode ignores high overflow
    wr(2'd0, 8'h23, "R4");
    wr(2'd2, 8'h55, "R4");
    tmr_8bit = 2'b01;
    tmr_hi_ovf = 2'b01; step("R4"); clear_in();
    chk("R4", dac_code, 12'h994);
    tmr_lo_ovf = 2'b01; step("R4"); clear_in();
    chk("R4", dac_code, 12'h554);
    tmr_8bit = 2'b00;
    tmr_hi_ovf = 2'b01; step("R4"); clear_in();
    chk("R4", dac_code, 12'h554);

    // R5: rising edge, three-edge latency
    wr(2'd0, 8'h43, "R5");
    wr(2'd2, 8'h77, "R5");
    cnv_pin = 1'b1;
    step("R5"); step("R5");
    chk("R5", dac_code, 12'h554);
    step("R5");
    chk("R5", dac_code, 12'h774);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      string tag;
      tag = mode_tag(m_mode);
      if ($urandom % 4 == 0) begin
        wr_en = 1;
        wr_addr = ($urandom % 16 == 0) ? 2'd0 : 2'($urandom % 4);
        wr_data = 8'($urandom);
      end
      tmr0_ovf   = ($urandom % 8 == 0);
      tmr1_ovf   = ($urandom % 8 == 0);
      tmr_lo_ovf = 2'($urandom % 4) & 2'($urandom % 4);
      tmr_hi_ovf = 2'($urandom % 4) & 2'($urandom % 4);
      if ($urandom % 32 == 0) tmr_8bit = 2'($urandom % 4);
      if ($urandom % 5 == 0) cnv_pin = ~cnv_pin;
      step(tag);
      clear_in();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule